// File: doc/BRIEF.md
# Configuration Window Decoder

This block sits between a CPU-side memory bus and the configuration request path of an express host bridge. Software maps a window of address space with a single update command that gives an enable, a base address and a size. Any CPU access of one, two or four bytes that lands inside the window has the base subtracted. The remaining offset is split into a bus number, a device, a function and a register offset. The access is then sent downstream as a request that stays up until it is acknowledged.

The downstream side answers with an acknowledge and a flag that tells whether a device was there. When no device answers, a read returns all ones of the access width and a write is dropped without any effect. Accesses outside the window get no response from this block, so another decoder on the CPU bus can claim them. The window can be moved or switched off at run time. An update that asks for a size the block cannot map is refused and flagged.

Top module: `cfg_window_decoder`

## Requirements
- R1: After reset the window is unmapped, no access hits it, and `cpu_busy`, `dn_req`, `cpu_rsp_valid` and `upd_err` are low.
- R2: For a hit, the offset is `addr - base`. Offset bits 11:0 go to `dn_reg`, bits 14:12 to `dn_fn`, bits 19:15 to `dn_dev` and bits 28:20 to `dn_bus`.
- R3: A legal size is a power of two from 2^20 to 2^28 bytes. An update with `upd_enable` high and any other size raises `upd_err` for one cycle after the update edge and leaves the mapping unchanged. When `upd_enable` is low the size is not checked.
- R4: An update always unmaps the current window first. With `upd_enable` high it then maps the new base and size, and the old range stops hitting. With `upd_enable` low the block stays unmapped.
- R5: An access hits only when base <= addr < base + size. A miss raises no `dn_req`, no `cpu_rsp_valid` and no `cpu_busy`.
- R6: For a hit, `dn_req` rises in the cycle after the accepting edge. It holds, with `dn_write`, `dn_len` (0 byte, 1 word, 2 dword), `dn_wdata` and the address fields stable and equal to the CPU values, until the edge where `dn_ack` is sampled high.
- R7: `cpu_rsp_valid` pulses for the one cycle after the acknowledge edge. For a read with `dn_present` high, `cpu_rdata` equals `dn_rdata`. `cpu_busy` then falls.
- R8: A read acknowledged with `dn_present` low returns 0xFF for a byte, 0xFFFF for a word and 0xFFFFFFFF for a dword.
- R9: A write is acknowledged with `cpu_rsp_valid` and `cpu_rdata` of zero whether or not a device was present. An absent device is never sent anything other than the single request.
- R10: `dn_bus` bits at or above the width the window size allows (log2(size) - 20) are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Window update command strobe |
| upd_enable | input | 1 | Map the window after unmapping it |
| upd_base | input | ADDR_W | New window base |
| upd_size | input | ADDR_W | New window size in bytes |
| upd_err | output | 1 | Illegal size was refused |
| cpu_valid | input | 1 | CPU access strobe, taken when not busy |
| cpu_write | input | 1 | 1 write, 0 read |
| cpu_len | input | 2 | 0 byte, 1 word, 2 dword |
| cpu_addr | input | ADDR_W | CPU address |
| cpu_wdata | input | 32 | Write data |
| cpu_busy | output | 1 | An access is in flight |
| cpu_rsp_valid | output | 1 | Response pulse |
| cpu_rdata | output | 32 | Read data of the response |
| dn_req | output | 1 | Downstream configuration request |
| dn_write | output | 1 | Request is a write |
| dn_len | output | 2 | Request length code |
| dn_bus | output | 9 | Bus number |
| dn_dev | output | 5 | Device number |
| dn_fn | output | 3 | Function number |
| dn_reg | output | 12 | Register offset |
| dn_wdata | output | 32 | Write data |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_present | input | 1 | A device answered |
| dn_rdata | input | 32 | Downstream read data |

## Verification
The assertions assume that `dn_ack` only comes while `dn_req` is high. They also assume that `cpu_valid` is offered for a single cycle while `cpu_busy` is low, and that no window update is issued while an access is in flight. The stimulus keeps to these rules: each access runs from its strobe through the acknowledge before the next command. Updates are only driven when the block is idle. The acknowledge is raised only after the bench has seen the request, sometimes after several cycles of delay.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  localparam int REG_W     = 12;
  localparam int FN_W      = 3;
  localparam int DEV_W     = 5;
  localparam int BUS_W     = 9;
  localparam int FN_LSB    = REG_W;
  localparam int DEV_LSB   = FN_LSB + FN_W;
  localparam int BUS_LSB   = DEV_LSB + DEV_W;
  localparam int MIN_LOG2  = 20;
  localparam int MAX_LOG2  = 28;
  localparam int DATA_W    = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} acc_state_e;

  function automatic logic [DATA_W-1:0] ones_for(input logic [1:0] len);
    case (len)
      2'd0:    ones_for = 32'h0000_00FF;
      2'd1:    ones_for = 32'h0000_FFFF;
      default: ones_for = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [4:0] log2_of(input logic [31:0] v);
    log2_of = 5'd0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) log2_of = 5'(i);
    end
  endfunction
endpackage

// File: rtl/cfgw_window.sv
module cfgw_window
  import cfgw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic              upd_enable,
  input  logic [ADDR_W-1:0] upd_base,
  input  logic [ADDR_W-1:0] upd_size,
  input  logic [ADDR_W-1:0] q_addr,
  output logic              upd_err,
  output logic              win_hit,
  output logic [ADDR_W-1:0] win_off,
  output logic [4:0]        win_log2
);
  localparam logic [ADDR_W-1:0] SIZE_MIN = ADDR_W'(1) << MIN_LOG2;
  localparam logic [ADDR_W-1:0] SIZE_MAX = ADDR_W'(1) << MAX_LOG2;

  logic              map_valid_q, map_valid_d;
  logic [ADDR_W-1:0] map_base_q, map_base_d;
  logic [4:0]        map_log2_q, map_log2_d;
  logic              err_q, err_d;
  logic              size_legal;
  logic [ADDR_W:0]   diff;

  assign size_legal = (upd_size != '0) && ((upd_size & (upd_size - 1'b1)) == '0)
                      && (upd_size >= SIZE_MIN) && (upd_size <= SIZE_MAX);

  always_comb begin
    map_valid_d = map_valid_q;
    map_base_d  = map_base_q;
    map_log2_d  = map_log2_q;
    err_d       = 1'b0;
    if (upd_valid) begin
      if (upd_enable && !size_legal) begin
        err_d = 1'b1;
      end else begin
        map_valid_d = upd_enable;
        if (upd_enable) begin
          map_base_d = upd_base;
          map_log2_d = log2_of(32'(upd_size));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_valid_q <= 1'b0;
      map_base_q  <= '0;
      map_log2_q  <= 5'(MIN_LOG2);
      err_q       <= 1'b0;
    end else begin
      map_valid_q <= map_valid_d;
      map_base_q  <= map_base_d;
      map_log2_q  <= map_log2_d;
      err_q       <= err_d;
    end
  end

  assign diff     = {1'b0, q_addr} - {1'b0, map_base_q};
  assign win_off  = diff[ADDR_W-1:0];
  assign win_hit  = map_valid_q && !diff[ADDR_W] && ((win_off >> map_log2_q) == '0);
  assign win_log2 = map_log2_q;
  assign upd_err  = err_q;

  assert_unmapped_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !map_valid_q |-> !win_hit);

  assert_refused_keeps_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_err |-> (map_valid_q == $past(map_valid_q)) && (map_base_q == $past(map_base_q))
                && (map_log2_q == $past(map_log2_q)));

  assert_size_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    map_valid_q |-> (map_log2_q >= 5'(MIN_LOG2)) && (map_log2_q <= 5'(MAX_LOG2)));
endmodule

// File: rtl/cfgw_field_split.sv
module cfgw_field_split
  import cfgw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] off,
  input  logic [4:0]        log2,
  output logic [BUS_W-1:0]  bus,
  output logic [DEV_W-1:0]  dev,
  output logic [FN_W-1:0]   fn,
  output logic [REG_W-1:0]  regoff
);
  logic [4:0]       bus_bits;
  logic [BUS_W-1:0] bus_keep;

  assign bus_bits = log2 - 5'(MIN_LOG2);
  assign bus_keep = (BUS_W'(1) << bus_bits) - 1'b1;

  assign regoff = off[REG_W-1:0];
  assign fn     = off[FN_LSB +: FN_W];
  assign dev    = off[DEV_LSB +: DEV_W];
  assign bus    = off[BUS_LSB +: BUS_W] & bus_keep;
endmodule

// File: rtl/cfgw_access_fsm.sv
module cfgw_access_fsm
  import cfgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              in_write,
  input  logic [1:0]        in_len,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [BUS_W-1:0]  in_bus,
  input  logic [DEV_W-1:0]  in_dev,
  input  logic [FN_W-1:0]   in_fn,
  input  logic [REG_W-1:0]  in_reg,
  input  logic              dn_ack,
  input  logic              dn_present,
  input  logic [DATA_W-1:0] dn_rdata,
  output logic              dn_req,
  output logic              dn_write,
  output logic [1:0]        dn_len,
  output logic [DATA_W-1:0] dn_wdata,
  output logic [BUS_W-1:0]  dn_bus,
  output logic [DEV_W-1:0]  dn_dev,
  output logic [FN_W-1:0]   dn_fn,
  output logic [REG_W-1:0]  dn_reg,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  acc_state_e        st_q, st_d;
  logic              cap_en, rsp_en;
  logic [DATA_W-1:0] rsp_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (go)     st_d = ST_REQ;
      ST_REQ:  if (dn_ack) st_d = ST_RSP;
      default:             st_d = ST_IDLE;
    endcase
  end

  assign cap_en = (st_q == ST_IDLE) && go;
  assign rsp_en = (st_q == ST_REQ) && dn_ack;

  always_comb begin
    if (dn_write)        rsp_d = '0;
    else if (dn_present) rsp_d = dn_rdata;
    else                 rsp_d = ones_for(dn_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_write <= 1'b0;
      dn_len   <= 2'd0;
      dn_wdata <= '0;
      dn_bus   <= '0;
      dn_dev   <= '0;
      dn_fn    <= '0;
      dn_reg   <= '0;
    end else if (cap_en) begin
      dn_write <= in_write;
      dn_len   <= in_len;
      dn_wdata <= in_wdata;
      dn_bus   <= in_bus;
      dn_dev   <= in_dev;
      dn_fn    <= in_fn;
      dn_reg   <= in_reg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsp_data <= '0;
    else if (rsp_en) rsp_data <= rsp_d;
  end

  assign dn_req    = (st_q == ST_REQ);
  assign rsp_valid = (st_q == ST_RSP);
  assign busy      = (st_q != ST_IDLE);

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && !dn_ack |=> dn_req && $stable(dn_write) && $stable(dn_len) && $stable(dn_wdata)
                          && $stable(dn_bus) && $stable(dn_dev) && $stable(dn_fn) && $stable(dn_reg));

  assert_rsp_follows_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && dn_ack |=> rsp_valid && !dn_req);

  assert_absent_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && dn_ack && !dn_write && !dn_present |=> rsp_data == ones_for($past(dn_len)));

  assert_write_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && dn_ack && dn_write |=> rsp_data == '0);

  assert_single_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && !busy);
endmodule

// File: rtl/cfg_window_decoder.sv
module cfg_window_decoder
  import cfgw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic              upd_enable,
  input  logic [ADDR_W-1:0] upd_base,
  input  logic [ADDR_W-1:0] upd_size,
  output logic              upd_err,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [1:0]        cpu_len,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_busy,
  output logic              cpu_rsp_valid,
  output logic [31:0]       cpu_rdata,
  output logic              dn_req,
  output logic              dn_write,
  output logic [1:0]        dn_len,
  output logic [8:0]        dn_bus,
  output logic [4:0]        dn_dev,
  output logic [2:0]        dn_fn,
  output logic [11:0]       dn_reg,
  output logic [31:0]       dn_wdata,
  input  logic              dn_ack,
  input  logic              dn_present,
  input  logic [31:0]       dn_rdata
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              win_hit;
  logic [ADDR_W-1:0] win_off;
  logic [4:0]        win_log2;
  logic [BUS_W-1:0]  sp_bus;
  logic [DEV_W-1:0]  sp_dev;
  logic [FN_W-1:0]   sp_fn;
  logic [REG_W-1:0]  sp_reg;
  logic              accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cfgw_window #(.ADDR_W(ADDR_W)) u_window (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .upd_valid  (upd_valid),
    .upd_enable (upd_enable),
    .upd_base   (upd_base),
    .upd_size   (upd_size),
    .q_addr     (cpu_addr),
    .upd_err    (upd_err),
    .win_hit    (win_hit),
    .win_off    (win_off),
    .win_log2   (win_log2)
  );

  cfgw_field_split #(.ADDR_W(ADDR_W)) u_split (
    .off    (win_off),
    .log2   (win_log2),
    .bus    (sp_bus),
    .dev    (sp_dev),
    .fn     (sp_fn),
    .regoff (sp_reg)
  );

  assign accept = cpu_valid && !cpu_busy && win_hit;

  cfgw_access_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .go         (accept),
    .in_write   (cpu_write),
    .in_len     (cpu_len),
    .in_wdata   (cpu_wdata),
    .in_bus     (sp_bus),
    .in_dev     (sp_dev),
    .in_fn      (sp_fn),
    .in_reg     (sp_reg),
    .dn_ack     (dn_ack),
    .dn_present (dn_present),
    .dn_rdata   (dn_rdata),
    .dn_req     (dn_req),
    .dn_write   (dn_write),
    .dn_len     (dn_len),
    .dn_wdata   (dn_wdata),
    .dn_bus     (dn_bus),
    .dn_dev     (dn_dev),
    .dn_fn      (dn_fn),
    .dn_reg     (dn_reg),
    .busy       (cpu_busy),
    .rsp_valid  (cpu_rsp_valid),
    .rsp_data   (cpu_rdata)
  );

  assert_miss_no_req_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    cpu_valid && !cpu_busy && !win_hit |=> !dn_req && !cpu_busy);

  assert_bus_width_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    accept |-> ((win_off >> win_log2) == '0) && ((sp_bus >> (win_log2 - 5'(MIN_LOG2))) == '0));
endmodule

// File: tb/tb_cfg_window_decoder.sv
`timescale 1ns/1ps
module tb_cfg_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_valid = 1'b0, upd_enable = 1'b0;
  logic [31:0] upd_base = '0, upd_size = '0;
  logic        upd_err;
  logic        cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [1:0]  cpu_len = 2'd0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_busy, cpu_rsp_valid;
  logic [31:0] cpu_rdata;
  logic        dn_req, dn_write;
  logic [1:0]  dn_len;
  logic [8:0]  dn_bus;
  logic [4:0]  dn_dev;
  logic [2:0]  dn_fn;
  logic [11:0] dn_reg;
  logic [31:0] dn_wdata;
  logic        dn_ack = 1'b0, dn_present = 1'b0;
  logic [31:0] dn_rdata = '0;

  int checks = 0, errors = 0, cycles = 0;
  bit exp_err = 1'b0, exp_rsp = 1'b0, mon_on = 1'b0;
  bit m_valid = 1'b0;
  longint m_base = 0, m_size = 0;

  always #2.5 clk = ~clk;

  cfg_window_decoder dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // every-cycle comparison of the pulse outputs against the model
  always @(negedge clk) begin
    cycles++;
    if (mon_on) begin
      chk(upd_err == exp_err, "R3", "upd_err per cycle", upd_err, exp_err);
      chk(cpu_rsp_valid == exp_rsp, "R7", "rsp_valid per cycle", cpu_rsp_valid, exp_rsp);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic bit legal_size(input longint s);
    return (s >= (64'd1 << 20)) && (s <= (64'd1 << 28)) && ((s & (s - 1)) == 0);
  endfunction

  task automatic update(input bit en, input longint base, input longint size, input string req);
    bit bad;
    bad = en && !legal_size(size);
    @(posedge clk); #1;
    upd_valid = 1'b1; upd_enable = en; upd_base = 32'(base); upd_size = 32'(size);
    @(posedge clk); #1;
    upd_valid = 1'b0;
    exp_err = bad;
    if (!bad) begin
      m_valid = en;
      if (en) begin m_base = base; m_size = size; end
    end
    chk(upd_err == bad, req, "update error flag", upd_err, bad);
    @(posedge clk); #1;
    exp_err = 1'b0;
  endtask

  task automatic access(input bit wr, input logic [1:0] len, input longint addr,
                        input logic [31:0] wd, input bit present, input logic [31:0] rd,
                        input int delay, input string req);
    bit hit;
    longint off;
    logic [31:0] exp_d;
    hit = m_valid && (addr >= m_base) && (addr < m_base + m_size);
    off = addr - m_base;
    @(posedge clk); #1;
    cpu_valid = 1'b1; cpu_write = wr; cpu_len = len; cpu_addr = 32'(addr); cpu_wdata = wd;
    @(posedge clk); #1;
    cpu_valid = 1'b0;
    if (!hit) begin
      chk(dn_req == 1'b0 && cpu_busy == 1'b0, req, "miss raised activity", {dn_req, cpu_busy}, 0);
      repeat (3) @(posedge clk);
      #1;
      chk(dn_req == 1'b0 && cpu_busy == 1'b0, req, "miss activity later", {dn_req, cpu_busy}, 0);
      return;
    end
    chk(dn_req == 1'b1, req, "request raised", dn_req, 1);
    chk(dn_reg == 12'(off), req, "register field", dn_reg, 12'(off));
    chk(dn_fn == 3'(off >> 12), req, "function field", dn_fn, 3'(off >> 12));
    chk(dn_dev == 5'(off >> 15), req, "device field", dn_dev, 5'(off >> 15));
    chk(dn_bus == 9'(off >> 20), req, "bus field", dn_bus, 9'(off >> 20));
    chk(dn_write == wr && dn_len == len, req, "kind and length", {dn_write, dn_len}, {wr, len});
    if (wr) chk(dn_wdata == wd, req, "write data", dn_wdata, wd);
    for (int i = 0; i < delay; i++) begin
      @(posedge clk); #1;
      chk(dn_req == 1'b1 && dn_reg == 12'(off), req, "request held", dn_req, 1);
    end
    dn_ack = 1'b1; dn_present = present; dn_rdata = rd;
    @(posedge clk); #1;
    dn_ack = 1'b0; dn_present = 1'b0; dn_rdata = '0;
    exp_rsp = 1'b1;
    if (wr)           exp_d = 32'h0;
    else if (present) exp_d = rd;
    else              exp_d = (len == 2'd0) ? 32'hFF : (len == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    chk(cpu_rsp_valid == 1'b1 && dn_req == 1'b0, req, "response after ack", cpu_rsp_valid, 1);
    chk(cpu_rdata == exp_d, req, "response data", cpu_rdata, exp_d);
    @(posedge clk); #1;
    exp_rsp = 1'b0;
    chk(cpu_busy == 1'b0, req, "idle after response", cpu_busy, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(cpu_busy == 0 && dn_req == 0 && cpu_rsp_valid == 0 && upd_err == 0, "R1",
        "reset outputs", {cpu_busy, dn_req, cpu_rsp_valid, upd_err}, 0);
    mon_on = 1'b1;
    // R1: nothing hits before mapping
    access(1'b0, 2'd2, 64'h0, 0, 1'b1, 32'h1234, 0, "R1");
    access(1'b0, 2'd2, 64'hE000_0000, 0, 1'b1, 32'h1234, 0, "R1");
    // R3: illegal size while unmapped is refused
    update(1'b1, 64'hE000_0000, 64'h30_0000, "R3");
    access(1'b0, 2'd2, 64'hE000_0000, 0, 1'b1, 32'h1, 0, "R3");
    // R4: map a 256 MiB window
    update(1'b1, 64'hE000_0000, 64'h1000_0000, "R4");
    // R2 and R7: field layout, present read
    access(1'b0, 2'd2, 64'hE000_0000 + (5 << 20) + (3 << 15) + (2 << 12) + 12'h1A4,
           0, 1'b1, 32'hCAFE_F00D, 0, "R2");
    access(1'b0, 2'd1, 64'hE000_0000 + (9'h0FF << 20) + (31 << 15) + (7 << 12) + 12'hFFE,
           0, 1'b1, 32'h0000_BEEF, 1, "R7");
    // R8: absent reads of each width
    access(1'b0, 2'd0, 64'hE010_0004, 0, 1'b0, 32'h5555_5555, 0, "R8");
    access(1'b0, 2'd1, 64'hE020_8002, 0, 1'b0, 32'h5555_5555, 2, "R8");
    access(1'b0, 2'd2, 64'hE030_0100, 0, 1'b0, 32'h5555_5555, 0, "R8");
    // R6: write held over a slow ack, data unchanged
    access(1'b1, 2'd2, 64'hE000_9010, 32'hA5A5_0F0F, 1'b1, 32'hDEAD_BEEF, 3, "R6");
    access(1'b1, 2'd0, 64'hE000_9011, 32'h0000_007E, 1'b1, 32'h0, 1, "R6");
    // R9: write to an absent device
    access(1'b1, 2'd1, 64'hE7F0_0000, 32'h0000_1234, 1'b0, 32'hFFFF_FFFF, 0, "R9");
    // R5: edges of the range
    access(1'b0, 2'd2, 64'hDFFF_FFFC, 0, 1'b1, 32'h1, 0, "R5");
    access(1'b0, 2'd2, 64'hF000_0000, 0, 1'b1, 32'h1, 0, "R5");
    access(1'b0, 2'd0, 64'hEFFF_FFFF, 0, 1'b1, 32'h77, 0, "R5");
    // R3: refused sizes keep the current mapping
    update(1'b1, 64'h4000_0000, 64'h2000_0000, "R3");
    update(1'b1, 64'h4000_0000, 64'h18_0000, "R3");
    update(1'b1, 64'h4000_0000, 64'h8_0000, "R3");
    access(1'b0, 2'd2, 64'hE000_0040, 0, 1'b1, 32'h0BAD_CAFE, 0, "R3");
    access(1'b0, 2'd2, 64'h4000_0000, 0, 1'b1, 32'h1, 0, "R3");
    // R4: remap to 1 MiB, old range misses
    update(1'b1, 64'h4000_0000, 64'h10_0000, "R4");
    access(1'b0, 2'd2, 64'hE000_0040, 0, 1'b1, 32'h1, 0, "R4");
    access(1'b0, 2'd2, 64'h4000_0000, 0, 1'b1, 32'h0102_0304, 0, "R4");
    // R10: top of a 1 MiB window has bus zero
    access(1'b0, 2'd0, 64'h400F_FFFF, 0, 1'b0, 32'h0, 0, "R10");
    access(1'b0, 2'd2, 64'h4010_0000, 0, 1'b1, 32'h1, 0, "R10");
    // R10: 2 MiB window, bus limited to one bit
    update(1'b1, 64'h4000_0000, 64'h20_0000, "R10");
    access(1'b0, 2'd2, 64'h401F_F004, 0, 1'b1, 32'h0000_0101, 0, "R10");
    // R4: disable unmaps; bad size with enable low is not an error
    update(1'b0, 64'h0, 64'h3, "R4");
    access(1'b0, 2'd2, 64'h4000_0000, 0, 1'b1, 32'h1, 0, "R4");
    access(1'b1, 2'd2, 64'h4000_1000, 32'h1, 1'b1, 32'h1, 0, "R4");
    repeat (2) @(posedge clk);
    #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule